// File: doc/BRIEF.md
# Privilege-Gated Counter Register Access Checker

This block sits beside the performance-counter configuration registers of a processor. It judges each access to those registers and returns a 2-bit result: the access completes, it traps to the default handler, or it traps to exception level 2 or level 3. The decision is combinational. It uses the current exception level, a flag that marks secure state below level 3, the level-2 trap-enable bit, the user-access enable register and the trap-enable bit of the level-3 debug control register.

The block also holds the registers that the decision depends on. These are the user-access enable register, an interrupt-enable register reached through a set view and a clear view, and the level-3 debug control register. The control register has a full-width native view and a 32-bit alias view. A write through the alias keeps only the bits in a valid mask. A register changes only on the clock edge of an access whose result is OK. A read whose result is not OK returns zero.

Top module: `cntr_access_gate`

## Requirements
- R1: Results are coded 0 = OK, 1 = trap to default, 2 = trap to level 2, 3 = trap to level 3. An access to the counter register (select 0) at level 0 while the user-access enable register is all zero gives 1. This check ranks above both tier traps.
- R2: Select 0 to 3 only: when the level is below 2, the level-2 trap-enable input is 1 and the secure flag is 0, the result is 2. In secure state, a level-2 trap never occurs.
- R3: Select 0 to 3 only: when the R2 trap does not apply, the level is below 3 and bit 6 of the level-3 debug control register is 1, the result is 3. At level 3 no tier trap occurs.
- R4: The user-access enable register (select 1) and the interrupt-enable views (select 2 and 3) do not use the level-0 user-access check of R1. They use only the R2 and R3 traps.
- R5: Permission faults give result 1. Select 1 can be read at level 0, but a write to it needs level 1 or higher. Select 2 and 3 need level 1 or higher. Select 4, the native control view, needs level 3. Select 5, the 32-bit alias, needs level 1 or higher. Select 6 and 7 always give 1.
- R6: A write to select 5 loads the control register with the low 32 data bits ANDed with the valid mask (default 0x0001C0C0) and clears the upper bits. A read of select 5 returns the low 32 bits. Select 4 reads and writes the full 64 bits.
- R7: After reset, the user-access enable, interrupt-enable and control registers all read zero.
- R8: In the interrupt-enable register, a 1 written through select 2 sets that bit and a 1 written through select 3 clears it. Zero bits leave the register unchanged. Both views read the current value.
- R9: A register changes only on the clock edge of a valid write whose result is 0. A read whose result is not 0 returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSel | input | 3 | Register select, codes as in R5 |
| accWdata | input | 64 | Write data |
| curLevel | input | 2 | Current exception level 0..3 |
| secureBelowTop | input | 1 | Secure state below level 3 |
| l2TrapEn | input | 1 | Trap-enable bit of the level-2 debug control register |
| accResult | output | 2 | Access result code |
| accRdata | output | 64 | Read data, zero unless the result is OK |

## Verification
Two functions can fall in the same cycle: the trap decision, which uses the control register's trap bit, and a write that changes that same bit. The bench provokes this with a level-1 write through the 32-bit alias while the trap bit is set. The alias is not subject to the tier traps, so this write must complete and take effect at the edge. The next level-1 counter access is then judged against the new bit value. The bench also checks that a trapped write through the set view leaves the interrupt-enable register unchanged when it is read back in a later access.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_TRAP_DFLT = 2'd1,
    RES_TRAP_L2   = 2'd2,
    RES_TRAP_L3   = 2'd3
  } accResult_e;

  typedef enum logic [2:0] {
    SEL_CNT    = 3'd0,
    SEL_UEN    = 3'd1,
    SEL_ISET   = 3'd2,
    SEL_ICLR   = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_CTRL32 = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrUen;
    logic    setInt;
    logic    clrInt;
    logic    wrCtrl;
    logic    wrCtrl32;
    logic    rdEn;
    regSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/cag_ctrl.sv
module cag_ctrl
  import cag_pkg::*;
(
  input  logic       accValid,
  input  logic       accWrite,
  input  logic [2:0] accSel,
  input  logic [1:0] curLevel,
  input  logic       secureBelowTop,
  input  logic       l2TrapEn,
  input  logic       uenNonZero,
  input  logic       l3TrapEn,
  output logic [1:0] accResult,
  output regStrobe_t stb
);
  logic       permFault;
  logic       userChk;
  logic       tierChk;
  accResult_e res;
  logic       go;

  always_comb begin
    permFault = 1'b0;
    userChk   = 1'b0;
    tierChk   = 1'b1;
    case (regSel_e'(accSel))
      SEL_CNT:  userChk = 1'b1;
      SEL_UEN:  permFault = accWrite && (curLevel == 2'd0);
      SEL_ISET,
      SEL_ICLR: permFault = (curLevel == 2'd0);
      SEL_CTRL: begin
        permFault = (curLevel != 2'd3);
        tierChk   = 1'b0;
      end
      SEL_CTRL32: begin
        permFault = (curLevel == 2'd0);
        tierChk   = 1'b0;
      end
      default:  permFault = 1'b1;
    endcase
  end

  always_comb begin
    if (permFault || (userChk && (curLevel == 2'd0) && !uenNonZero))
      res = RES_TRAP_DFLT;
    else if (tierChk && (curLevel < 2'd2) && l2TrapEn && !secureBelowTop)
      res = RES_TRAP_L2;
    else if (tierChk && (curLevel != 2'd3) && l3TrapEn)
      res = RES_TRAP_L3;
    else
      res = RES_OK;
  end

  assign accResult = res;
  assign go        = accValid && (res == RES_OK);

  always_comb begin
    stb          = '0;
    stb.rdSel    = regSel_e'(accSel);
    stb.rdEn     = go && !accWrite;
    stb.wrUen    = go && accWrite && (accSel == SEL_UEN);
    stb.setInt   = go && accWrite && (accSel == SEL_ISET);
    stb.clrInt   = go && accWrite && (accSel == SEL_ICLR);
    stb.wrCtrl   = go && accWrite && (accSel == SEL_CTRL);
    stb.wrCtrl32 = go && accWrite && (accSel == SEL_CTRL32);
  end
endmodule

// File: rtl/cag_dp.sv
module cag_dp
  import cag_pkg::*;
#(
  parameter int          UEN_W      = 4,
  parameter int          INT_W      = 8,
  parameter int          CTRL_W     = 64,
  parameter int          ALIAS_W    = 32,
  parameter logic [31:0] ALIAS_MASK = 32'h0001_C0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        stb,
  input  logic [CTRL_W-1:0] accWdata,
  output logic [UEN_W-1:0]  uenVal,
  output logic [INT_W-1:0]  intVal,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic [CTRL_W-1:0] accRdata
);
  localparam logic [ALIAS_W-1:0] MASK_W = ALIAS_MASK[ALIAS_W-1:0];

  logic [CTRL_W-1:0] aliasNext;
  logic [CTRL_W-1:0] aliasView;

  generate
    if (ALIAS_W < CTRL_W) begin : g_narrow
      assign aliasNext = {{(CTRL_W-ALIAS_W){1'b0}}, accWdata[ALIAS_W-1:0] & MASK_W};
      assign aliasView = {{(CTRL_W-ALIAS_W){1'b0}}, ctrlVal[ALIAS_W-1:0]};
    end else begin : g_full
      assign aliasNext = accWdata & CTRL_W'(MASK_W);
      assign aliasView = ctrlVal;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uenVal  <= '0;
      intVal  <= '0;
      ctrlVal <= '0;
    end else begin
      if (stb.wrUen)    uenVal  <= accWdata[UEN_W-1:0];
      if (stb.setInt)   intVal  <= intVal | accWdata[INT_W-1:0];
      if (stb.clrInt)   intVal  <= intVal & ~accWdata[INT_W-1:0];
      if (stb.wrCtrl)   ctrlVal <= accWdata;
      if (stb.wrCtrl32) ctrlVal <= aliasNext;
    end
  end

  always_comb begin
    accRdata = '0;
    if (stb.rdEn) begin
      case (stb.rdSel)
        SEL_UEN:    accRdata = CTRL_W'(uenVal);
        SEL_ISET,
        SEL_ICLR:   accRdata = CTRL_W'(intVal);
        SEL_CTRL:   accRdata = ctrlVal;
        SEL_CTRL32: accRdata = aliasView;
        default:    accRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cntr_access_gate.sv
module cntr_access_gate
  import cag_pkg::*;
#(
  parameter int          UEN_W      = 4,
  parameter int          INT_W      = 8,
  parameter int          CTRL_W     = 64,
  parameter int          ALIAS_W    = 32,
  parameter int          TRAP_BIT   = 6,
  parameter logic [31:0] ALIAS_MASK = 32'h0001_C0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [2:0]        accSel,
  input  logic [CTRL_W-1:0] accWdata,
  input  logic [1:0]        curLevel,
  input  logic              secureBelowTop,
  input  logic              l2TrapEn,
  output logic [1:0]        accResult,
  output logic [CTRL_W-1:0] accRdata
);
  regStrobe_t        stb;
  logic [UEN_W-1:0]  uenVal;
  logic [INT_W-1:0]  intVal;
  logic [CTRL_W-1:0] ctrlVal;

  cag_ctrl u_ctrl (
    .accValid       (accValid),
    .accWrite       (accWrite),
    .accSel         (accSel),
    .curLevel       (curLevel),
    .secureBelowTop (secureBelowTop),
    .l2TrapEn       (l2TrapEn),
    .uenNonZero     (|uenVal),
    .l3TrapEn       (ctrlVal[TRAP_BIT]),
    .accResult      (accResult),
    .stb            (stb)
  );

  cag_dp #(
    .UEN_W      (UEN_W),
    .INT_W      (INT_W),
    .CTRL_W     (CTRL_W),
    .ALIAS_W    (ALIAS_W),
    .ALIAS_MASK (ALIAS_MASK)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .accWdata (accWdata),
    .uenVal   (uenVal),
    .intVal   (intVal),
    .ctrlVal  (ctrlVal),
    .accRdata (accRdata)
  );
endmodule

// File: rtl/cag_chk.sv
module cag_chk #(
  parameter int          UEN_W      = 4,
  parameter int          INT_W      = 8,
  parameter int          CTRL_W     = 64,
  parameter int          ALIAS_W    = 32,
  parameter logic [31:0] ALIAS_MASK = 32'h0001_C0C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accValid,
  input logic              accWrite,
  input logic [2:0]        accSel,
  input logic [CTRL_W-1:0] accWdata,
  input logic [1:0]        curLevel,
  input logic              secureBelowTop,
  input logic [1:0]        accResult,
  input logic [UEN_W-1:0]  uenVal,
  input logic [INT_W-1:0]  intVal,
  input logic [CTRL_W-1:0] ctrlVal
);
  // R1
  user_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && curLevel == 2'd0 && accSel == 3'd0 && uenVal == '0) |-> accResult == 2'd1);

  // R2
  secure_no_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && secureBelowTop) |-> accResult != 2'd2);

  // R3
  top_level_no_tier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && curLevel == 2'd3) |-> accResult < 2'd2);

  // R9
  hold_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accWrite && accResult != 2'd0)
      |=> ($stable(uenVal) && $stable(intVal) && $stable(ctrlVal)));

  // R6
  alias_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accWrite && accSel == 3'd5 && accResult == 2'd0)
      |=> ctrlVal == CTRL_W'($past(accWdata[ALIAS_W-1:0]) & ALIAS_MASK[ALIAS_W-1:0]));

  // R6
  native_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accWrite && accSel == 3'd4 && accResult == 2'd0)
      |=> ctrlVal == $past(accWdata));

  // R8
  set_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accWrite && accSel == 3'd2 && accResult == 2'd0)
      |=> intVal == ($past(intVal) | $past(accWdata[INT_W-1:0])));

  // R7
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (uenVal == '0 && intVal == '0 && ctrlVal == '0));
endmodule

bind cntr_access_gate cag_chk #(
  .UEN_W      (UEN_W),
  .INT_W      (INT_W),
  .CTRL_W     (CTRL_W),
  .ALIAS_W    (ALIAS_W),
  .ALIAS_MASK (ALIAS_MASK)
) u_chk (.*);

// File: tb/cntr_access_gate_tb.sv
`timescale 1ns/1ps
module cntr_access_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [2:0]  accSel = 3'd0;
  logic [63:0] accWdata = '0;
  logic [1:0]  curLevel = 2'd0;
  logic        secureBelowTop = 1'b0;
  logic        l2TrapEn = 1'b0;
  logic [1:0]  accResult;
  logic [63:0] accRdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cntr_access_gate u_dut (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accWrite(accWrite),
    .accSel(accSel), .accWdata(accWdata), .curLevel(curLevel),
    .secureBelowTop(secureBelowTop), .l2TrapEn(l2TrapEn),
    .accResult(accResult), .accRdata(accRdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, sample mid-cycle, register update at next posedge.
  task automatic access(input logic [1:0] lvl, input logic sec, input logic l2,
                        input logic [2:0] sel, input logic wr, input logic [63:0] wd,
                        output logic [1:0] res, output logic [63:0] rd);
    @(negedge clk);
    curLevel = lvl; secureBelowTop = sec; l2TrapEn = l2;
    accSel = sel; accWrite = wr; accWdata = wd; accValid = 1'b1;
    #1;
    res = accResult;
    rd  = accRdata;
    @(posedge clk);
    #0.5;
    accValid = 1'b0;
    accWrite = 1'b0;
  endtask

  task automatic t_reset();
    logic [1:0] r; logic [63:0] d;
    access(2'd1, 1'b0, 1'b0, 3'd1, 1'b0, '0, r, d);
    check("R7 uen reset result", 64'(r), 64'd0);
    check("R7 uen reset value", d, 64'd0);
    access(2'd1, 1'b0, 1'b0, 3'd2, 1'b0, '0, r, d);
    check("R7 int reset value", d, 64'd0);
    access(2'd3, 1'b0, 1'b0, 3'd4, 1'b0, '0, r, d);
    check("R7 ctrl reset value", d, 64'd0);
  endtask

  task automatic t_user();
    logic [1:0] r; logic [63:0] d;
    access(2'd0, 1'b0, 1'b1, 3'd0, 1'b0, '0, r, d);
    check("R1 level0 counter with uen zero", 64'(r), 64'd1);
    check("R9 trapped read data", d, 64'd0);
    access(2'd1, 1'b0, 1'b0, 3'd1, 1'b1, 64'd1, r, d);
    check("R5 uen write at level1", 64'(r), 64'd0);
    access(2'd0, 1'b0, 1'b0, 3'd0, 1'b0, '0, r, d);
    check("R1 level0 counter with uen set", 64'(r), 64'd0);
  endtask

  task automatic t_l2();
    logic [1:0] r; logic [63:0] d;
    access(2'd1, 1'b0, 1'b1, 3'd0, 1'b0, '0, r, d);
    check("R2 level1 nonsecure", 64'(r), 64'd2);
    access(2'd1, 1'b1, 1'b1, 3'd0, 1'b0, '0, r, d);
    check("R2 secure suppresses", 64'(r), 64'd0);
    access(2'd0, 1'b0, 1'b1, 3'd0, 1'b0, '0, r, d);
    check("R2 level0 with uen set", 64'(r), 64'd2);
    access(2'd2, 1'b0, 1'b1, 3'd0, 1'b0, '0, r, d);
    check("R2 level2 not trapped", 64'(r), 64'd0);
  endtask

  task automatic t_perm();
    logic [1:0] r; logic [63:0] d;
    access(2'd0, 1'b0, 1'b0, 3'd1, 1'b1, 64'd5, r, d);
    check("R5 uen write at level0", 64'(r), 64'd1);
    access(2'd1, 1'b0, 1'b0, 3'd1, 1'b0, '0, r, d);
    check("R9 uen kept after faulted write", d, 64'd1);
    access(2'd1, 1'b0, 1'b0, 3'd1, 1'b1, 64'd0, r, d);
    access(2'd0, 1'b0, 1'b0, 3'd1, 1'b0, '0, r, d);
    check("R4 uen read at level0 skips user check", 64'(r), 64'd0);
    access(2'd0, 1'b0, 1'b0, 3'd2, 1'b0, '0, r, d);
    check("R5 set view at level0", 64'(r), 64'd1);
    access(2'd2, 1'b0, 1'b0, 3'd4, 1'b0, '0, r, d);
    check("R5 native ctrl at level2", 64'(r), 64'd1);
    access(2'd3, 1'b0, 1'b0, 3'd7, 1'b0, '0, r, d);
    check("R5 reserved select", 64'(r), 64'd1);
  endtask

  task automatic t_l3();
    logic [1:0] r; logic [63:0] d;
    access(2'd3, 1'b0, 1'b0, 3'd4, 1'b1, 64'hABCD_0000_0000_0040, r, d);
    check("R5 native ctrl write at level3", 64'(r), 64'd0);
    access(2'd1, 1'b0, 1'b0, 3'd2, 1'b0, '0, r, d);
    check("R3 level1 trap to level3", 64'(r), 64'd3);
    access(2'd1, 1'b0, 1'b1, 3'd0, 1'b0, '0, r, d);
    check("R2 level2 trap ranks above level3", 64'(r), 64'd2);
    access(2'd1, 1'b1, 1'b1, 3'd3, 1'b0, '0, r, d);
    check("R3 secure falls to level3 trap", 64'(r), 64'd3);
    access(2'd2, 1'b0, 1'b0, 3'd1, 1'b0, '0, r, d);
    check("R4 uen register gets level3 trap", 64'(r), 64'd3);
    access(2'd3, 1'b0, 1'b1, 3'd0, 1'b0, '0, r, d);
    check("R3 no tier trap at level3", 64'(r), 64'd0);
    access(2'd0, 1'b0, 1'b1, 3'd0, 1'b0, '0, r, d);
    check("R1 user check ranks first", 64'(r), 64'd1);
  endtask

  task automatic t_alias();
    logic [1:0] r; logic [63:0] d;
    access(2'd1, 1'b0, 1'b0, 3'd5, 1'b0, '0, r, d);
    check("R6 alias read low half", d, 64'h40);
    access(2'd1, 1'b0, 1'b0, 3'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, r, d);
    check("R6 alias write not tier trapped", 64'(r), 64'd0);
    access(2'd3, 1'b0, 1'b0, 3'd4, 1'b0, '0, r, d);
    check("R6 alias write masked and upper cleared", d, 64'h0001_C0C0);
    access(2'd1, 1'b0, 1'b0, 3'd5, 1'b1, 64'd0, r, d);
    access(2'd1, 1'b0, 1'b0, 3'd0, 1'b0, '0, r, d);
    check("R3 trap gone after alias clear", 64'(r), 64'd0);
    access(2'd0, 1'b0, 1'b0, 3'd5, 1'b1, 64'h40, r, d);
    check("R5 alias at level0", 64'(r), 64'd1);
  endtask

  task automatic t_int();
    logic [1:0] r; logic [63:0] d;
    access(2'd1, 1'b0, 1'b0, 3'd2, 1'b1, 64'h0F, r, d);
    access(2'd1, 1'b0, 1'b0, 3'd2, 1'b1, 64'h30, r, d);
    access(2'd1, 1'b0, 1'b0, 3'd2, 1'b0, '0, r, d);
    check("R8 set view accumulates", d, 64'h3F);
    access(2'd1, 1'b0, 1'b0, 3'd3, 1'b1, 64'h05, r, d);
    access(2'd1, 1'b0, 1'b0, 3'd3, 1'b1, 64'h00, r, d);
    access(2'd1, 1'b0, 1'b0, 3'd3, 1'b0, '0, r, d);
    check("R8 clear view clears ones only", d, 64'h3A);
    access(2'd1, 1'b0, 1'b1, 3'd2, 1'b1, 64'hC0, r, d);
    check("R9 trapped set write result", 64'(r), 64'd2);
    access(2'd1, 1'b0, 1'b0, 3'd2, 1'b0, '0, r, d);
    check("R9 trapped set write ignored", d, 64'h3A);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_user();
    t_l2();
    t_perm();
    t_l3();
    t_alias();
    t_int();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule